// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Full Flag

This block buffers 18-bit words between two unrelated clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. Both pointers cross domains as gray code through two-stage synchronizers. The full flag is computed on the write side and the empty flag on the read side, and all flags are active low. An active-low almost-full flag warns the producer once the fill level comes within a programmable margin of capacity. That flag is computed on the write side only.

Two 16-bit offset registers (almost-empty and almost-full) use the ordinary data ports. When the shared load strobe is high, a write-enabled cycle stores the low 16 data bits into whichever offset the write-side pointer selects. A read-enabled cycle shows the offset that the read-side pointer selects on the output. Each pointer alternates between the two offsets. A build parameter selects the output behaviour: standard mode, where a read fetches the next word, or first-word-fall-through mode, where the head word shows on the output without a read request and the output stage adds one word of capacity.

Top module: `dcfifo_af`

## Requirements
- R1: After reset: empty_n=0, full_n=1, af_n=1, dout=0. Both offset-select pointers point at the almost-empty offset. The offsets return to their parameter defaults (AE_DEF=2, AF_DEF=3).
- R2: In standard mode, words leave in the order they entered. A read accepted at a read-clock edge places the next word on dout at that same edge.
- R3: full_n goes low at the write edge that brings the stored count to DEPTH (16 by default). Writes presented while full_n is low store nothing.
- R4: Reads presented while empty_n is low do not change dout and do not advance the read pointer.
- R5: af_n is updated only at write-clock edges. It goes low at the write edge where count + m reaches DEPTH, m being the almost-full offset.
- R6: af_n returns high once count falls to DEPTH-(m+1). This is seen at the third write-clock edge after the read edge, because the read pointer first passes two synchronizer stages.
- R7: With ld=1 and wen=1, successive write edges store din[15:0] into the almost-empty offset, then the almost-full offset, then wrap back. din[17:16] are discarded and no data word is stored.
- R8: With ld=1 and ren=1, successive read edges place {2'b00, almost-empty offset}, then {2'b00, almost-full offset}, then wrap back on dout. No data word is consumed.
- R9: The write and read pointers cross domains as gray code and change by at most one bit per cycle. Data written in one domain is read intact in the other.
- R10: With FWFT=1, the head word appears on dout and empty_n rises without any read request. A read advances to the next word, and total capacity is DEPTH+1.
- R11: In standard mode, empty_n rises at the third read-clock edge after the write edge that stored a word into an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| wen | input | 1 | Write enable (data, or offset when ld=1) |
| ren | input | 1 | Read enable (data, or offset readback when ld=1) |
| ld | input | 1 | Selects offset access for both enables |
| din | input | 18 | Write data; offsets use bits 15:0 |
| dout | output | 18 | Read data or offset readback |
| full_n | output | 1 | Low when no space is left |
| empty_n | output | 1 | Low when nothing can be read |
| af_n | output | 1 | Almost-full flag, low when count + m >= DEPTH |

## Verification
A read or offset readback shows on dout at the read edge that accepts it, and both full_n and af_n move at the write edge that stores a word. The bench therefore samples these at the first sampling point after the stimulus. The cross-domain effects are due exactly three edges of the far clock after the causing edge. These are the rise of empty_n after a write, the rise of af_n after a read, and the head word falling through in FWFT mode. The bench samples one point before and one point at that edge, so a missing or an extra synchronizer stage is caught. Both clocks run at the same rate with the read edge 3 ns after the write edge, so every sample point falls well clear of both edges.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    localparam int OFS_W = 16;
    typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} ofs_sel_e;
endpackage

// File: rtl/dcfifo_gray_sync.sv
module dcfifo_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gray_in;
            s2_q <= s1_q;
        end
    end

    // gray to binary: each bit is the parity of all higher gray bits
    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_out[i] = ^s2_q[W-1:i];
    end
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem_q [0:DEPTH-1];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcfifo_wr.sv
module dcfifo_wr
    import dcfifo_pkg::*;
#(
    parameter int AW     = 4,
    parameter int AE_DEF = 2,
    parameter int AF_DEF = 3
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             wen,
    input  logic             ld,
    input  logic [OFS_W-1:0] din_lo,
    input  logic [AW:0]      rbin_s,
    output logic             mem_we,
    output logic [AW-1:0]    waddr,
    output logic [AW:0]      wgray,
    output logic             full_n,
    output logic             af_n,
    output logic [OFS_W-1:0] ae_off,
    output logic [OFS_W-1:0] af_off
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = OFS_W + 2;

    typedef struct packed {
        logic [AW:0]      wbin;
        logic [AW:0]      wgray;
        logic             full_n;
        logic             af_n;
        logic [OFS_W-1:0] ae_off;
        logic [OFS_W-1:0] af_off;
        ofs_sel_e         sel;
    } wst_t;

    wst_t          st_d, st_q;
    logic          wr_go;
    logic [AW:0]   cnt_d;
    logic [CW-1:0] fill_sum;

    always_comb begin
        st_d  = st_q;
        wr_go = wen && !ld && st_q.full_n;
        if (wr_go) st_d.wbin = st_q.wbin + 1'b1;
        st_d.wgray = st_d.wbin ^ (st_d.wbin >> 1);
        if (wen && ld) begin
            if (st_q.sel == SEL_AE) st_d.ae_off = din_lo;
            else                    st_d.af_off = din_lo;
            st_d.sel = (st_q.sel == SEL_AE) ? SEL_AF : SEL_AE;
        end
        cnt_d       = st_d.wbin - rbin_s;
        fill_sum    = CW'(cnt_d) + CW'(st_q.af_off);
        st_d.full_n = (cnt_d != (AW+1)'(DEPTH));
        st_d.af_n   = (fill_sum < CW'(DEPTH));
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wbin: '0, wgray: '0, full_n: 1'b1, af_n: 1'b1,
                      ae_off: OFS_W'(AE_DEF), af_off: OFS_W'(AF_DEF), sel: SEL_AE};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we = wr_go;
    assign waddr  = st_q.wbin[AW-1:0];
    assign wgray  = st_q.wgray;
    assign full_n = st_q.full_n;
    assign af_n   = st_q.af_n;
    assign ae_off = st_q.ae_off;
    assign af_off = st_q.af_off;

    a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        (!st_q.full_n && wen && !ld) |=> $stable(st_q.wbin));
    a_r5_full_implies_af: assert property (@(posedge wclk) disable iff (!rst_n)
        !st_q.full_n |-> !st_q.af_n);
    a_r7_load_keeps_wptr: assert property (@(posedge wclk) disable iff (!rst_n)
        ld |=> $stable(st_q.wbin));
    a_r9_wgray_one_bit: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(st_q.wgray ^ $past(st_q.wgray)) <= 1);
endmodule

// File: rtl/dcfifo_rd.sv
module dcfifo_rd
    import dcfifo_pkg::*;
#(
    parameter int DW   = 18,
    parameter int AW   = 4,
    parameter bit FWFT = 1'b0
) (
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             ren,
    input  logic             ld,
    input  logic [AW:0]      wbin_s,
    input  logic [DW-1:0]    rdata,
    input  logic [OFS_W-1:0] ae_off,
    input  logic [OFS_W-1:0] af_off,
    output logic [AW-1:0]    raddr,
    output logic [AW:0]      rgray,
    output logic [DW-1:0]    dout,
    output logic             empty_n
);
    typedef struct packed {
        logic [AW:0]      rbin;
        logic [AW:0]      rgray;
        logic             valid;
        logic             show_ofs;
        logic [DW-1:0]    data;
        logic [OFS_W-1:0] ofs;
        ofs_sel_e         sel;
    } rst_t;

    rst_t        st_d, st_q;
    logic        ram_ne, take, valid_nx;
    logic [AW:0] rbin_nx;

    assign ram_ne  = (st_q.rbin != wbin_s);
    assign rbin_nx = st_q.rbin + (AW+1)'(take);

    if (FWFT) begin : g_fwft
        // output register refills itself whenever it is free or being read
        assign take     = !ld && ram_ne && (!st_q.valid || ren);
        assign valid_nx = take || (st_q.valid && !(ren && !ld));
    end else begin : g_std
        assign take     = ren && !ld && st_q.valid;
        assign valid_nx = (rbin_nx != wbin_s);
    end

    always_comb begin
        st_d       = st_q;
        st_d.rbin  = rbin_nx;
        st_d.rgray = rbin_nx ^ (rbin_nx >> 1);
        st_d.valid = valid_nx;
        if (take) begin
            st_d.data     = rdata;
            st_d.show_ofs = 1'b0;
        end
        if (ren && ld) begin
            st_d.ofs      = (st_q.sel == SEL_AE) ? ae_off : af_off;
            st_d.show_ofs = 1'b1;
            st_d.sel      = (st_q.sel == SEL_AE) ? SEL_AF : SEL_AE;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rbin: '0, rgray: '0, valid: 1'b0, show_ofs: 1'b0,
                      data: '0, ofs: '0, sel: SEL_AE};
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr   = st_q.rbin[AW-1:0];
    assign rgray   = st_q.rgray;
    assign empty_n = st_q.valid;
    assign dout    = st_q.show_ofs ? DW'(st_q.ofs) : st_q.data;

    if (!FWFT) begin : g_chk_std
        a_r4_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
            (!st_q.valid && ren && !ld) |=> $stable(st_q.rbin));
    end else begin : g_chk_fwft
        a_r10_fall_through: assert property (@(posedge rclk) disable iff (!rst_n)
            (!st_q.valid && !ld && ram_ne) |=> st_q.valid);
    end
    a_r8_readback_keeps_rptr: assert property (@(posedge rclk) disable iff (!rst_n)
        ld |=> $stable(st_q.rbin));
    a_r9_rgray_one_bit: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(st_q.rgray ^ $past(st_q.rgray)) <= 1);
endmodule

// File: rtl/dcfifo_af.sv
module dcfifo_af
    import dcfifo_pkg::*;
#(
    parameter int DW     = 18,
    parameter int AW     = 4,
    parameter int AE_DEF = 2,
    parameter int AF_DEF = 3,
    parameter bit FWFT   = 1'b0
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic          ren,
    input  logic          ld,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          full_n,
    output logic          empty_n,
    output logic          af_n
);
    logic             mem_we;
    logic [AW-1:0]    waddr, raddr;
    logic [AW:0]      wgray, rgray, wbin_s, rbin_s;
    logic [DW-1:0]    rdata;
    logic [OFS_W-1:0] ae_off, af_off;

    dcfifo_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    dcfifo_wr #(.AW(AW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wen(wen), .ld(ld), .din_lo(din[OFS_W-1:0]),
        .rbin_s(rbin_s), .mem_we(mem_we), .waddr(waddr), .wgray(wgray),
        .full_n(full_n), .af_n(af_n), .ae_off(ae_off), .af_off(af_off)
    );

    dcfifo_gray_sync #(.W(AW+1)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_s)
    );

    dcfifo_gray_sync #(.W(AW+1)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_s)
    );

    dcfifo_rd #(.DW(DW), .AW(AW), .FWFT(FWFT)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .ren(ren), .ld(ld), .wbin_s(wbin_s),
        .rdata(rdata), .ae_off(ae_off), .af_off(af_off), .raddr(raddr),
        .rgray(rgray), .dout(dout), .empty_n(empty_n)
    );
endmodule

// File: tb/sim_dcfifo_af.sv
module sim_dcfifo_af;
    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wen = 1'b0, ren = 1'b0, ld = 1'b0;
    logic [17:0] din = '0;
    logic [17:0] dout0, dout1;
    logic        full0_n, empty0_n, af0_n, full1_n, empty1_n, af1_n;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    // fill table: {expected full_n, expected af_n, din[17:0]}, one write per entry
    localparam int NFILL = 18;
    localparam logic [19:0] FILL_TBL [0:NFILL-1] = '{
        20'hC0101, 20'hC0102, 20'hC0103, 20'hC0104, 20'hC0105, 20'hC0106,
        20'hC0107, 20'hC0108, 20'hC0109, 20'hC010A, 20'hC010B, 20'h8010C,
        20'h8010D, 20'h8010E, 20'h8010F, 20'h00110, 20'h00111, 20'h00112
    };

    always #5 wclk = ~wclk;
    initial begin
        #3;
        forever #5 rclk = ~rclk;
    end

    dcfifo_af #(.FWFT(1'b0)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen(wen), .ren(ren), .ld(ld),
        .din(din), .dout(dout0), .full_n(full0_n), .empty_n(empty0_n), .af_n(af0_n)
    );

    dcfifo_af #(.FWFT(1'b1)) u1 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen(wen), .ren(ren), .ld(ld),
        .din(din), .dout(dout1), .full_n(full1_n), .empty_n(empty1_n), .af_n(af1_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // drive at a write-clock falling edge, return at the next one
    task automatic step(input logic w, input logic r, input logic l, input logic [17:0] d);
        wen = w; ren = r; ld = l; din = d;
        @(negedge wclk);
        wen = 1'b0; ren = 1'b0; ld = 1'b0; din = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 18'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge wclk);
        do_reset();
        chk("R1 empty_n", empty0_n, 0);
        chk("R1 full_n", full0_n, 1);
        chk("R1 af_n", af0_n, 1);
        chk("R1 dout", dout0, 0);

        // default offsets read back, almost-empty first
        step(1'b0, 1'b1, 1'b1, 18'h0);
        chk("R1 R8 default ae", dout0, 18'h00002);
        step(1'b0, 1'b1, 1'b1, 18'h0);
        chk("R1 R8 default af", dout0, 18'h00003);

        // load ae=5, af=4, then wrap to ae=7 with upper bits set
        step(1'b1, 1'b0, 1'b1, 18'h30005);
        step(1'b1, 1'b0, 1'b1, 18'h00004);
        step(1'b1, 1'b0, 1'b1, 18'h30007);
        step(1'b0, 1'b1, 1'b1, 18'h0);
        chk("R7 R8 ae wrap, din[17:16] dropped", dout0, 18'h00007);
        step(1'b0, 1'b1, 1'b1, 18'h0);
        chk("R7 R8 af", dout0, 18'h00004);
        step(1'b0, 1'b1, 1'b1, 18'h0);
        chk("R8 readback wrap", dout0, 18'h00007);
        idle(4);
        chk("R7 load stores no data", empty0_n, 0);

        // table-driven fill, m=4: af at 12 words, full at 16
        for (int k = 0; k < NFILL; k++) begin
            step(1'b1, 1'b0, 1'b0, FILL_TBL[k][17:0]);
            chk("R3 full_n in fill", full0_n, FILL_TBL[k][19]);
            chk("R5 af_n in fill", af0_n, FILL_TBL[k][18]);
        end
        idle(5);
        chk("R11 empty_n after fill", empty0_n, 1);

        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, 1'b0, 18'h0);
            chk("R2 order", dout0, 18'h00101 + 18'(i));
        end
        idle(5);
        chk("R6 af_n held at D-m", af0_n, 0);
        chk("R3 full_n released", full0_n, 1);

        step(1'b0, 1'b1, 1'b0, 18'h0);
        chk("R2 order", dout0, 18'h00105);
        chk("R6 af_n not yet", af0_n, 0);
        idle(2);
        chk("R6 af_n before third write edge", af0_n, 0);
        idle(1);
        chk("R6 af_n at D-(m+1)", af0_n, 1);

        for (int i = 0; i < 11; i++) begin
            step(1'b0, 1'b1, 1'b0, 18'h0);
            chk("R2 R9 order", dout0, 18'h00106 + 18'(i));
        end
        chk("R3 writes while full dropped", empty0_n, 0);

        step(1'b0, 1'b1, 1'b0, 18'h0);
        chk("R4 read while empty", dout0, 18'h00110);

        step(1'b1, 1'b0, 1'b0, 18'h2AAAA);
        chk("R11 empty_n low right after write", empty0_n, 0);
        idle(1);
        chk("R11 empty_n low at second read edge", empty0_n, 0);
        idle(1);
        chk("R11 empty_n at third read edge", empty0_n, 1);
        step(1'b0, 1'b1, 1'b0, 18'h0);
        chk("R4 R9 pointer kept by ignored read", dout0, 18'h2AAAA);

        do_reset();
        chk("R1 dout after reset", dout0, 0);
        chk("R1 af_n after reset", af0_n, 1);
        chk("R1 fwft empty_n", empty1_n, 0);

        // first-word-fall-through: default af offset 3 again
        step(1'b1, 1'b0, 1'b0, 18'h01000);
        idle(1);
        chk("R10 not yet through", empty1_n, 0);
        idle(1);
        chk("R10 head word falls through", dout1, 18'h01000);
        chk("R10 empty_n high", empty1_n, 1);
        chk("R2 standard mode holds dout", dout0, 0);
        for (int i = 1; i <= 16; i++) step(1'b1, 1'b0, 1'b0, 18'h01000 + 18'(i));
        idle(5);
        chk("R10 fwft full", full1_n, 0);
        chk("R3 standard full", full0_n, 0);
        chk("R5 fwft af_n", af1_n, 0);
        for (int i = 0; i <= 16; i++) begin
            chk("R10 fwft order", dout1, 18'h01000 + 18'(i));
            if (i > 0) chk("R2 standard order", dout0, 18'h01000 + 18'(i - 1));
            step(1'b0, 1'b1, 1'b0, 18'h0);
        end
        chk("R10 fwft holds DEPTH+1, now empty", empty1_n, 0);
        chk("R4 standard extra read ignored", dout0, 18'h0100F);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule